// File: doc/BRIEF.md
# Reconfigurable Multiply-Accumulate Processing Element

This block is one processing element of a coarse-grained compute array. It takes two signed 16-bit operands, each picked from one of several 16-bit input ports. It returns a 36-bit result from one of these operations: pass, add, subtract, multiply, multiply-accumulate, bitwise logic or shift. The result is 36 bits wide so that a long run of 16x16 products can be summed without losing precision. Data moves through four stages in order: an operand-capture stage, two execute stages and an output stage. The multiplier and the accumulate adder are split across the two execute stages, with a register between them.

A local sequencer replaces fetch and decode. It reads a small instruction memory of 64-bit words and holds each word active for a programmed number of cycles. It then steps to the next address, and after the programmed end address it returns to address 0. Each word also sets whether each execute stage and the output stage is bypassed, and the extra input and output delay used to line the element up with its neighbours. The word's 11-bit network field goes straight out to the routing fabric. A plain address/data write port loads the memory.

Top module: `stream_pe`

## Requirements
- R1: Opcode 0 passes operand A, opcode 1 adds and opcode 2 subtracts (A minus B). All three treat the operands as signed and sign-extend the result to 36 bits without wrap.
- R2: Opcodes 5, 6 and 7 give the 16-bit AND, OR and XOR, zero-extended. Opcode 8 shifts A left by B[3:0] within 16 bits, zero-extended. Opcode 9 shifts A arithmetically right by B[3:0], sign-extended. Bits B[15:4] are ignored by both shifts.
- R3: Opcode 3 gives the signed 16x16 product, sign-extended from 32 to 36 bits.
- R4: Opcode 4 adds the signed product to the accumulator once per sample and outputs the new sum. A sample issued with instruction bit 38 set starts from zero instead of the old sum.
- R5: With no stage bypassed, an operand change shows at the result 4 clock edges later. Each of bit 35 (execute 1), bit 36 (execute 2) and bit 37 (output stage) removes one edge. With all three set, the result follows the captured operands after the very next edge.
- R6: Field [40:39] adds that many edges of delay before operand capture. Field [42:41] adds that many edges after the output stage.
- R7: Field [32:31] picks the input port for operand A and field [34:33] picks the port for operand B. Port p occupies in_data[16p+15:16p].
- R8: Field [3:0] holds an instruction active for its value plus one cycles while run is high. When the hold ends, the address steps by one, or goes to 0 if the current address equals the end field [8:4].
- R9: After the last memory word (address 19 by default), the address goes to 0 even when the end field is larger.
- R10: While run is low, the instruction address and the hold count do not change.
- R11: net_ctrl always shows field [19:9] of the instruction that is currently active.
- R12: While reset is asserted, result is 0 and the active address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in sync with clk |
| run | input | 1 | Lets the sequencer advance |
| cfg_we | input | 1 | Instruction memory write strobe |
| cfg_addr | input | 5 | Instruction memory write address |
| cfg_wdata | input | 64 | Instruction word to write |
| in_data | input | NUM_IN*16 | Operand input ports, packed |
| result | output | 36 | Result after the output delay |
| net_ctrl | output | 11 | Network field of the active instruction |

## Verification
The bench builds the element with its defaults: four input ports, twenty memory words and a maximum delay of three. Four ports let every operand-select code name a real port. A maximum delay of three covers every value of both delay fields. With twenty words the bench can fill the whole memory and step the address up to the last word, so the forced return to 0 is actually reached. The same settings cover every bypass combination that the latency checks use, along with multiply-accumulate runs with and without bypass.

// File: rtl/spe_pkg.sv
package spe_pkg;
  localparam int OP_W   = 16;
  localparam int RES_W  = 36;
  localparam int HOLD_W = 4;
  localparam int ADDR_W = 5;
  localparam int NET_W  = 11;
  localparam int SEL_W  = 2;
  localparam int DLY_W  = 2;
  localparam int INSTR_W = 64;

  typedef enum logic [3:0] {
    OP_PASS = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_MUL = 4'd3,
    OP_MAC  = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
    OP_SHL  = 4'd8, OP_SRA = 4'd9
  } op_e;

  // instruction word, most significant field first
  typedef struct packed {
    logic [20:0]       spare;     // 63:43
    logic [DLY_W-1:0]  out_dly;   // 42:41
    logic [DLY_W-1:0]  in_dly;    // 40:39
    logic              acc_clr;   // 38
    logic              byp_dst;   // 37
    logic              byp_e2;    // 36
    logic              byp_e1;    // 35
    logic [SEL_W-1:0]  sel_b;     // 34:33
    logic [SEL_W-1:0]  sel_a;     // 32:31
    logic [3:0]        op;        // 30:27
    logic [6:0]        rsvd;      // 26:20
    logic [NET_W-1:0]  net;       // 19:9
    logic [ADDR_W-1:0] end_addr;  // 8:4
    logic [HOLD_W-1:0] hold;      // 3:0
  } instr_t;

  // control that travels with each sample
  typedef struct packed {
    op_e              op;
    logic             byp1;
    logic             byp2;
    logic             byp3;
    logic             clr;
    logic [DLY_W-1:0] odly;
  } ctrl_t;
endpackage

// File: rtl/spe_sequencer.sv
module spe_sequencer
  import spe_pkg::*;
#(
  parameter int DEPTH = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [INSTR_W-1:0] cfg_wdata,
  output instr_t             instr_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [HOLD_W-1:0]  cnt_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [INSTR_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]  pc_q, pc_d;
  logic [HOLD_W-1:0]  cnt_q, cnt_d;
  instr_t             cur;
  logic               wr_en;

  assign wr_en = cfg_we && (cfg_addr <= LAST);

  always_ff @(posedge clk) begin
    if (wr_en) mem[cfg_addr] <= cfg_wdata;
  end

  assign cur = instr_t'(mem[pc_q]);

  always_comb begin
    pc_d  = pc_q;
    cnt_d = cnt_q;
    if (run) begin
      if (cnt_q == cur.hold) begin
        cnt_d = '0;
        if ((pc_q == cur.end_addr) || (pc_q == LAST)) pc_d = '0;
        else                                           pc_d = pc_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      pc_q  <= pc_d;
      cnt_q <= cnt_d;
    end
  end

  assign instr_o = cur;
  assign pc_o    = pc_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/spe_tapline.sv
module spe_tapline
  import spe_pkg::*;
#(
  parameter int W       = 16,
  parameter int MAX_DLY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     d,
  input  logic [DLY_W-1:0] sel,
  output logic [W-1:0]     q
);
  logic [W-1:0] tap [MAX_DLY+1];

  assign tap[0] = d;

  genvar k;
  generate
    for (k = 1; k <= MAX_DLY; k++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap[k] <= '0;
        else        tap[k] <= tap[k-1];
      end
    end
  endgenerate

  always_comb begin
    q = tap[MAX_DLY];
    for (int i = 0; i <= MAX_DLY; i++) begin
      if (int'(sel) == i) q = tap[i];
    end
  end
endmodule

// File: rtl/spe_datapath.sv
module spe_datapath
  import spe_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_IN*OP_W-1:0] in_bus,
  input  logic [SEL_W-1:0]       sel_a,
  input  logic [SEL_W-1:0]       sel_b,
  input  ctrl_t                  issue,
  output logic [RES_W-1:0]       res_o,
  output logic [DLY_W-1:0]       odly_o,
  output logic                   mac_live_o,
  output logic [RES_W-1:0]       acc_o
);
  localparam int EXT = RES_W - OP_W;

  function automatic logic [RES_W-1:0] sx16(input logic [OP_W-1:0] v);
    return {{EXT{v[OP_W-1]}}, v};
  endfunction

  function automatic logic [RES_W-1:0] exe1_f(input op_e op,
                                               input logic [OP_W-1:0] a,
                                               input logic [OP_W-1:0] b);
    logic signed [2*OP_W-1:0] prod;
    logic [OP_W-1:0]          sh;
    prod = $signed(a) * $signed(b);
    sh   = '0;
    case (op)
      OP_PASS: return sx16(a);
      OP_ADD:  return sx16(a) + sx16(b);
      OP_SUB:  return sx16(a) - sx16(b);
      OP_MUL,
      OP_MAC:  return {{(RES_W-2*OP_W){prod[2*OP_W-1]}}, prod};
      OP_AND:  return {{EXT{1'b0}}, a & b};
      OP_OR:   return {{EXT{1'b0}}, a | b};
      OP_XOR:  return {{EXT{1'b0}}, a ^ b};
      OP_SHL: begin
        sh = a << b[3:0];
        return {{EXT{1'b0}}, sh};
      end
      OP_SRA: begin
        sh = $signed(a) >>> b[3:0];
        return sx16(sh);
      end
      default: return '0;
    endcase
  endfunction

  // source select stage
  logic [OP_W-1:0] a_d, b_d, a_q, b_q;
  ctrl_t           cs_q;

  always_comb begin
    a_d = '0;
    b_d = '0;
    for (int p = 0; p < NUM_IN; p++) begin
      if (sel_a == SEL_W'(p)) a_d = in_bus[p*OP_W +: OP_W];
      if (sel_b == SEL_W'(p)) b_d = in_bus[p*OP_W +: OP_W];
    end
  end

  // execute 1
  logic [RES_W-1:0] f1, e1_q, v1;
  ctrl_t            c1_q, k1;

  assign f1 = exe1_f(cs_q.op, a_q, b_q);
  assign v1 = cs_q.byp1 ? f1 : e1_q;
  assign k1 = cs_q.byp1 ? cs_q : c1_q;

  // execute 2
  logic [RES_W-1:0] acc_q, acc_d, acc_sum, f2, e2_q, v2;
  ctrl_t            c2_q, k2;
  logic             mac_live;

  assign mac_live = (k1.op == OP_MAC);
  assign acc_sum  = (k1.clr ? '0 : acc_q) + v1;
  assign acc_d    = mac_live ? acc_sum : acc_q;
  assign f2       = mac_live ? acc_sum : v1;
  assign v2       = k1.byp2 ? f2 : e2_q;
  assign k2       = k1.byp2 ? k1 : c2_q;

  // destination select
  logic [RES_W-1:0] d_q;
  ctrl_t            c3_q, kd;

  assign kd = k2.byp3 ? k2 : c3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      cs_q  <= '0;
      e1_q  <= '0;
      c1_q  <= '0;
      acc_q <= '0;
      e2_q  <= '0;
      c2_q  <= '0;
      d_q   <= '0;
      c3_q  <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      cs_q  <= issue;
      e1_q  <= f1;
      c1_q  <= cs_q;
      acc_q <= acc_d;
      e2_q  <= f2;
      c2_q  <= k1;
      d_q   <= v2;
      c3_q  <= k2;
    end
  end

  assign res_o      = k2.byp3 ? v2 : d_q;
  assign odly_o     = kd.odly;
  assign mac_live_o = mac_live;
  assign acc_o      = acc_q;
endmodule

// File: rtl/stream_pe.sv
module stream_pe
  import spe_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int DEPTH   = 20,
  parameter int MAX_DLY = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [INSTR_W-1:0]     cfg_wdata,
  input  logic [NUM_IN*OP_W-1:0] in_data,
  output logic [RES_W-1:0]       result,
  output logic [NET_W-1:0]       net_ctrl
);
  localparam int BUS_W = NUM_IN * OP_W;

  // reset release aligned to clk
  logic rs0_q, rs1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_sync_n = rs1_q;

  instr_t            cur_instr;
  logic [ADDR_W-1:0] seq_pc;
  logic [HOLD_W-1:0] seq_cnt;

  spe_sequencer #(.DEPTH(DEPTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .instr_o  (cur_instr),
    .pc_o     (seq_pc),
    .cnt_o    (seq_cnt)
  );

  logic [BUS_W-1:0] in_dly_bus;

  spe_tapline #(.W(BUS_W), .MAX_DLY(MAX_DLY)) u_in_dly (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    (in_data),
    .sel  (cur_instr.in_dly),
    .q    (in_dly_bus)
  );

  ctrl_t issue;
  always_comb begin
    issue.op   = op_e'(cur_instr.op);
    issue.byp1 = cur_instr.byp_e1;
    issue.byp2 = cur_instr.byp_e2;
    issue.byp3 = cur_instr.byp_dst;
    issue.clr  = cur_instr.acc_clr;
    issue.odly = cur_instr.out_dly;
  end

  logic [RES_W-1:0] dp_res, dp_acc;
  logic [DLY_W-1:0] dp_odly;
  logic             dp_mac;

  spe_datapath #(.NUM_IN(NUM_IN)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_bus    (in_dly_bus),
    .sel_a     (cur_instr.sel_a),
    .sel_b     (cur_instr.sel_b),
    .issue     (issue),
    .res_o     (dp_res),
    .odly_o    (dp_odly),
    .mac_live_o(dp_mac),
    .acc_o     (dp_acc)
  );

  spe_tapline #(.W(RES_W), .MAX_DLY(MAX_DLY)) u_out_dly (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    (dp_res),
    .sel  (dp_odly),
    .q    (result)
  );

  assign net_ctrl = cur_instr.net;

  logic unused_bits;
  assign unused_bits = ^{cur_instr.rsvd, cur_instr.spare, seq_pc, seq_cnt, dp_mac, dp_acc};
endmodule

// File: rtl/spe_chk.sv
module spe_chk
  import spe_pkg::*;
#(
  parameter int DEPTH = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [ADDR_W-1:0] pc,
  input logic [HOLD_W-1:0] cnt,
  input logic [HOLD_W-1:0] hold,
  input logic              mac_live,
  input logic [RES_W-1:0]  acc
);
  // R9
  pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pc) < DEPTH);

  // R10
  seq_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(pc) && $stable(cnt)));

  // R8
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt != hold)) |=> (pc == $past(pc)));

  // R8
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt == hold)) |=> ((pc == '0) || (pc == $past(pc) + 1'b1)));

  // R4
  acc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_live |=> $stable(acc));
endmodule

bind stream_pe spe_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .run     (run),
  .pc      (seq_pc),
  .cnt     (seq_cnt),
  .hold    (cur_instr.hold),
  .mac_live(dp_mac),
  .acc     (dp_acc)
);

// File: tb/stream_pe_tb.sv
module stream_pe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IN = 4;

  logic        clk, rst_n, run, cfg_we;
  logic [4:0]  cfg_addr;
  logic [63:0] cfg_wdata;
  logic [NUM_IN*16-1:0] in_data;
  logic [35:0] result;
  logic [10:0] net_ctrl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  stream_pe u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .in_data(in_data),
    .result(result), .net_ctrl(net_ctrl)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [35:0] exp;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{4'd0, 16'h8001, 16'h0000, 36'hFFFFF8001},
    '{4'd1, 16'h7FFF, 16'h7FFF, 36'h00000FFFE},
    '{4'd1, 16'h8000, 16'h8000, 36'hFFFFF0000},
    '{4'd2, 16'h0003, 16'h0005, 36'hFFFFFFFFE},
    '{4'd3, 16'h8000, 16'h8000, 36'h040000000},
    '{4'd3, 16'hFFFF, 16'h0007, 36'hFFFFFFFF9},
    '{4'd3, 16'h7FFF, 16'h8000, 36'hFC0008000},
    '{4'd5, 16'hF0F0, 16'h3C3C, 36'h000003030},
    '{4'd6, 16'hF0F0, 16'h3C3C, 36'h00000FCFC},
    '{4'd7, 16'hF0F0, 16'h3C3C, 36'h00000CCCC},
    '{4'd8, 16'h8421, 16'hFFF4, 36'h000004210},
    '{4'd9, 16'h8000, 16'h0003, 36'hFFFFFF000},
    '{4'd9, 16'h7000, 16'hFFE4, 36'h000000700},
    '{4'd2, 16'h8000, 16'h7FFF, 36'hFFFFF0001}
  };

  function automatic logic [63:0] mk(input logic [3:0] op, input logic [1:0] sa,
      input logic [1:0] sb, input logic b1, input logic b2, input logic b3,
      input logic clr, input logic [1:0] id, input logic [1:0] od,
      input logic [3:0] hold, input logic [4:0] ea, input logic [10:0] net);
    logic [63:0] w;
    w = '0;
    w[3:0] = hold;  w[8:4] = ea;   w[19:9] = net;
    w[30:27] = op;  w[32:31] = sa; w[34:33] = sb;
    w[35] = b1;     w[36] = b2;    w[37] = b3;   w[38] = clr;
    w[40:39] = id;  w[42:41] = od;
    return w;
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    if (op == 4'd3) return "R3 multiply";
    if (op <= 4'd2) return "R1 pass/add/sub";
    return "R2 logic/shift";
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] addr, input logic [63:0] data);
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic set_port(input int p, input logic [15:0] v);
    in_data[p*16 +: 16] = v;
  endtask

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic lat_test(input logic b1, input logic b2, input logic b3,
                          input logic [1:0] id, input logic [1:0] od, input string tag);
    int lat;
    lat = 3 - int'(b1) - int'(b2) - int'(b3) + int'(id) + int'(od);
    wr(5'd0, mk(4'd0, 2'd0, 2'd1, b1, b2, b3, 1'b0, id, od, 4'd0, 5'd0, 11'd0));
    set_port(0, 16'h1234);
    repeat (10) step();
    set_port(0, 16'h0567);
    if (lat == 0) check(tag, result, 36'h000001234);
    for (int m = 0; m <= lat; m++) begin
      step();
      if (m == lat - 1) check(tag, result, 36'h000001234);
      if (m == lat)     check(tag, result, 36'h000000567);
    end
  endtask

  task automatic mac_run(input logic byp, input string tag);
    int lat, e;
    lat = byp ? 0 : 3;
    run = 1'b0;
    wr(5'd0, mk(4'd4, 2'd2, 2'd1, byp, byp, byp, 1'b1, 2'd0, 2'd0, 4'd0, 5'd3, 11'd0));
    wr(5'd1, mk(4'd4, 2'd2, 2'd1, byp, byp, byp, 1'b0, 2'd0, 2'd0, 4'd2, 5'd1, 11'd0));
    set_port(2, 16'h0100);
    set_port(1, 16'hFFFD);
    run = 1'b1;
    for (int m = 0; m < 12; m++) begin
      step();
      if (m >= lat) begin
        e = (((m - lat) % 4) + 1) * (-768);
        check(tag, result, 36'(e));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [10:0] seq_exp [9];
    bit found;
    rst_n = 1'b0; run = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; in_data = '0;
    repeat (3) step();
    // R12 reset state
    check("R12 result in reset", result, 36'h0);
    rst_n = 1'b1;
    repeat (3) step();

    // vector table, one instruction looping at address 0
    wr(5'd0, mk(4'd0, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd0, 5'd0, 11'd0));
    run = 1'b1;
    set_port(0, 16'h5555);
    set_port(3, 16'hAAAA);
    for (int i = 0; i < 14; i++) begin
      wr(5'd0, mk(VECS[i].op, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0,
                  4'd0, 5'd0, 11'(i)));
      set_port(2, VECS[i].a);
      set_port(1, VECS[i].b);
      repeat (6) step();
      check(tag_of(VECS[i].op), result, VECS[i].exp);
    end

    // R7 operand port select
    wr(5'd0, mk(4'd0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd0, 5'd0, 11'd0));
    repeat (6) step();
    check("R7 select port3", result, 36'hFFFFFAAAA);
    wr(5'd0, mk(4'd2, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd0, 5'd0, 11'd0));
    repeat (6) step();
    check("R7 select port0 minus port3", result, 36'h00000AAAB);

    // R5 bypass latency, R6 programmable delays
    lat_test(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, "R5 no bypass");
    lat_test(1'b1, 1'b1, 1'b1, 2'd0, 2'd0, "R5 full bypass");
    lat_test(1'b1, 1'b0, 1'b0, 2'd0, 2'd0, "R5 bypass exe1");
    lat_test(1'b0, 1'b1, 1'b1, 2'd0, 2'd0, "R5 bypass exe2+dst");
    lat_test(1'b1, 1'b1, 1'b1, 2'd1, 2'd2, "R6 delays 1/2");
    lat_test(1'b0, 1'b0, 1'b0, 2'd3, 2'd3, "R6 delays 3/3");

    // R4 accumulate with periodic clear
    mac_run(1'b0, "R4 mac pipelined");
    mac_run(1'b1, "R4 mac bypassed");

    // R8 hold counts and cyclic stepping, R11 network field
    run = 1'b0;
    wr(5'd0, mk(4'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd2, 5'd5, 11'h011));
    wr(5'd1, mk(4'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd0, 5'd5, 11'h022));
    wr(5'd2, mk(4'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd1, 5'd2, 11'h033));
    check("R11 net field at start", 36'(net_ctrl), 36'h011);
    seq_exp = '{11'h011, 11'h011, 11'h022, 11'h033, 11'h033,
                11'h011, 11'h011, 11'h011, 11'h022};
    run = 1'b1;
    for (int m = 0; m < 9; m++) begin
      step();
      check("R8 sequence", 36'(net_ctrl), 36'(seq_exp[m]));
    end

    // R10 run low freezes
    run = 1'b0;
    for (int m = 0; m < 4; m++) begin
      step();
      check("R10 frozen", 36'(net_ctrl), 36'h022);
    end
    run = 1'b1;
    step();
    check("R10 resumes", 36'(net_ctrl), 36'h033);

    // R9 wrap at last word
    run = 1'b0;
    for (int k = 0; k < 20; k++) begin
      wr(5'(k), mk(4'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0,
                   4'd0, 5'd31, 11'(11'h100 + k)));
    end
    run = 1'b1;
    found = 0;
    for (int m = 0; m < 40 && !found; m++) begin
      step();
      if (net_ctrl == 11'h113) found = 1;
    end
    check("R9 reached last word", 36'(found), 36'h1);
    step();
    check("R9 wrap to 0", 36'(net_ctrl), 36'h100);

    // R12 reset in mid-run
    repeat (3) step();
    rst_n = 1'b0;
    #1;
    check("R12 address 0 in reset", 36'(net_ctrl), 36'h100);
    check("R12 result 0 in reset", result, 36'h0);
    repeat (2) step();
    rst_n = 1'b1;
    repeat (3) step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule